// File: doc/BRIEF.md
# Vertical Split Fetch Substitution

This block sits beside the video fetch path of a tile-based display engine. It lets a band of tile columns on the left or right side of the screen take its background from a private 1 KB expansion RAM and from one dedicated 4 KB pattern bank. That band can then scroll vertically on its own. The block watches every video memory fetch. It tracks which tile column the renderer is working on by counting nametable fetches since the last detected scanline start. When a fetch falls inside the band, it raises an override strobe one cycle later. With the strobe it supplies either a substitute data byte or a pattern-memory address. An outside multiplexer then uses that result in place of the normal fetch result.

A scanline detector elsewhere supplies three signals: the scanline-start pulse, the in-frame flag and the scanline count. The CPU programs these settings through a small register port:

- the enable and side-select bits,
- the delimiter column,
- the vertical scroll,
- the bank,
- the expansion RAM mode.

The CPU also fills the expansion RAM through a write port. Fetches arrive as a valid-qualified stream with no ready. The renderer cannot be stalled, so the block accepts a fetch in every cycle in which `fetch_valid` is high. The override output is likewise valid-only, and the consumer must take it in the cycle it appears.

Top module: `split_fetch_sub`

## Requirements
- R1: After reset, `ovr_valid`, `ovr_is_addr`, `ovr_data` and `ovr_paddr` are all zero. All settings reset to zero: split disabled, left side, delimiter 0, scroll 0, bank 0, mode 0.
- R2: A tile count is cleared by `line_start` and advances by one on every nametable fetch. It does not advance on other fetches. When `line_start` and a nametable fetch fall in the same cycle, that fetch sees a count of 0. The column used by a nametable fetch is (count + 2) mod 42.
- R3: A nametable fetch lies in the band when its column is at most 32 and one of these holds: the side bit is set and the column is at least the delimiter, or the side bit is clear and the column is below the delimiter.
- R4: The effective vertical scroll is (programmed scroll + `line_cnt`) mod 240, taken from the values present in the fetch cycle.
- R5: An in-band nametable fetch produces `ovr_valid`=1, `ovr_is_addr`=0 one cycle later. It carries `ovr_data` = expansion RAM at index ((vscroll & 0xF8) << 2) | column.
- R6: An attribute fetch while the band flag is set produces a data override. Its byte is expansion RAM at 0x3C0 | ((index & 0x380) >> 4) | ((index & 0x1F) >> 2), where the index is the one stored by the last in-band nametable fetch.
- R7: A pattern fetch while the band flag is set produces `ovr_valid`=1, `ovr_is_addr`=1. It carries `ovr_paddr` = (bank mod 2^BANK_W)·0x1000 + ((addr & 0xFF8) | (vscroll & 7)).
- R8: The band flag is set by an in-band nametable fetch and cleared by any nametable fetch that is not substituted. Attribute and pattern fetches with the flag clear give no override.
- R9: An override happens only when all three hold: mode ≤ 1, the enable bit is 1, and `in_frame` is 1. Otherwise all outputs stay zero. The tile count still advances while overrides are blocked.
- R10: Register writes (`cfg_sel` values):
  - 0: bit0 enable, bit1 right side.
  - 1: delimiter in bits 4:0.
  - 2: vertical scroll.
  - 3: bank.
  - 4: mode in bits 1:0.

  A write takes effect from the following cycle. A fetch in the same cycle still sees the old value.
- R11: Fetch classes:
  - Pattern fetch: address bit 13 is clear.
  - Nametable fetch: addresses 0x2000–0x2FFF whose low 10 bits are below 0x3C0.
  - Attribute fetch: every other address with bit 13 set, including 0x3000–0x3FFF.
- R12: `xr_we` writes `xr_wdata` to expansion RAM at `xr_waddr`. A read in the same cycle at the same address returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| xr_we | input | 1 | Expansion RAM write strobe |
| xr_waddr | input | 10 | Expansion RAM write address |
| xr_wdata | input | 8 | Expansion RAM write data |
| fetch_valid | input | 1 | A video fetch is present this cycle |
| fetch_addr | input | 14 | Video fetch address |
| line_start | input | 1 | Scanline start detected this cycle |
| in_frame | input | 1 | Renderer is inside the visible frame |
| line_cnt | input | 8 | Current scanline count |
| ovr_valid | output | 1 | Override strobe, one cycle after the fetch |
| ovr_is_addr | output | 1 | 1: `ovr_paddr` is valid; 0: `ovr_data` is valid |
| ovr_data | output | 8 | Substitute nametable or attribute byte, zero otherwise |
| ovr_paddr | output | BANK_W+12 | Substitute pattern address, zero otherwise |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the scanline-start clear of the tile count and the nametable-fetch increment. The bench drives every line's first nametable fetch together with `line_start`. It also drives a lone `line_start` followed by a line that carries no start pulse. The column each fetch lands in shows up directly in the expansion RAM index, and so in the returned byte.

The second pair is a register or expansion RAM write and a fetch that reads the written state in the same cycle. This is provoked with a scroll write alongside a nametable fetch, and with an expansion RAM write to the very index being fetched. A behavioural model judges the result on every clock: it applies the fetch with the old state before committing the write.

// File: rtl/split_pkg.sv
package split_pkg;
  localparam int XRAM_AW = 10;
  localparam int XRAM_DW = 8;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_DELIM  = 3'd1;
  localparam logic [2:0] SEL_SCROLL = 3'd2;
  localparam logic [2:0] SEL_BANK   = 3'd3;
  localparam logic [2:0] SEL_MODE   = 3'd4;

  typedef enum logic [1:0] {FK_NONE, FK_NAME, FK_ATTR, FK_PATT} fetch_kind_t;

  typedef struct packed {
    logic       en;
    logic       right;
    logic [4:0] delim;
    logic [7:0] scroll;
    logic [7:0] bank;
    logic [1:0] mode;
  } split_cfg_t;

  function automatic fetch_kind_t classify(input logic v, input logic [13:0] a);
    fetch_kind_t k;
    if (!v)                                 k = FK_NONE;
    else if (!a[13])                        k = FK_PATT;
    else if (!a[12] && (a[9:6] != 4'hF))    k = FK_NAME;
    else                                    k = FK_ATTR;
    return k;
  endfunction
endpackage

// File: rtl/split_cfg_regs.sv
module split_cfg_regs
  import split_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  output split_cfg_t cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: begin
          cfg.en    <= wdata[0];
          cfg.right <= wdata[1];
        end
        SEL_DELIM:  cfg.delim  <= wdata[4:0];
        SEL_SCROLL: cfg.scroll <= wdata;
        SEL_BANK:   cfg.bank   <= wdata;
        SEL_MODE:   cfg.mode   <= wdata[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/split_xram.sv
module split_xram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/split_col_track.sv
module split_col_track #(
  parameter int COLS    = 42,
  parameter int COL_OFS = 2,
  parameter int CW      = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          nt_fetch,
  output logic [CW-1:0] col_now
);
  localparam logic [CW-1:0] START_COL = CW'(COL_OFS % COLS);
  localparam logic [CW-1:0] LAST      = CW'(COLS - 1);

  logic [CW-1:0] col_q;

  always_comb begin
    if (line_start)    col_now = START_COL;
    else if (nt_fetch) col_now = (col_q == LAST) ? '0 : col_q + 1'b1;
    else               col_now = col_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= START_COL;
    else        col_q <= col_now;
  end
endmodule

// File: rtl/split_fetch_sub.sv
module split_fetch_sub
  import split_pkg::*;
#(
  parameter int BANK_W   = 6,
  parameter int COLS     = 42,
  parameter int COL_OFS  = 2,
  parameter int LAST_COL = 32,
  parameter int LINES    = 240
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [7:0]           cfg_wdata,
  input  logic                 xr_we,
  input  logic [9:0]           xr_waddr,
  input  logic [7:0]           xr_wdata,
  input  logic                 fetch_valid,
  input  logic [13:0]          fetch_addr,
  input  logic                 line_start,
  input  logic                 in_frame,
  input  logic [7:0]           line_cnt,
  output logic                 ovr_valid,
  output logic                 ovr_is_addr,
  output logic [7:0]           ovr_data,
  output logic [BANK_W+11:0]   ovr_paddr
);
  localparam int CW = $clog2(COLS);
  localparam logic [8:0] WRAP1 = 9'(LINES);
  localparam logic [8:0] WRAP2 = 9'(2 * LINES);

  split_cfg_t          cfg;
  fetch_kind_t         kind;
  logic [CW-1:0]       col_now;
  logic [7:0]          scroll_q;
  logic [8:0]          vsum;
  logic [7:0]          vs;
  logic                active, in_band;
  logic                hit_nt, hit_at, hit_pt;
  logic [XRAM_AW-1:0]  idx_now, idx_q, attr_addr, rd_addr;
  logic [7:0]          rd_data;
  logic                flag_q, valid_q, is_addr_q;
  logic [BANK_W+11:0]  paddr_q;
  logic [2:0]          unused_bits;

  split_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata), .cfg(cfg)
  );

  assign kind = classify(fetch_valid, fetch_addr);

  split_col_track #(.COLS(COLS), .COL_OFS(COL_OFS), .CW(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .nt_fetch(kind == FK_NAME), .col_now(col_now)
  );

  // effective vertical scroll, reduced modulo the line count
  assign scroll_q = cfg.scroll;
  assign vsum     = {1'b0, scroll_q} + {1'b0, line_cnt};
  always_comb begin
    if (vsum >= WRAP2)      vs = 8'(vsum - WRAP2);
    else if (vsum >= WRAP1) vs = 8'(vsum - WRAP1);
    else                    vs = vsum[7:0];
  end

  assign active  = cfg.en && (cfg.mode <= 2'd1) && in_frame;
  assign in_band = (col_now <= CW'(LAST_COL)) &&
                   (cfg.right ? (col_now >= CW'(cfg.delim)) : (col_now < CW'(cfg.delim)));

  assign idx_now   = {vs[7:3], 5'b0} | XRAM_AW'(col_now);
  assign attr_addr = {4'hF, idx_q[9:7], idx_q[4:2]};
  assign rd_addr   = (kind == FK_ATTR) ? attr_addr : idx_now;

  assign hit_nt = (kind == FK_NAME) && active && in_band;
  assign hit_at = (kind == FK_ATTR) && active && flag_q;
  assign hit_pt = (kind == FK_PATT) && active && flag_q;

  split_xram #(.AW(XRAM_AW), .DW(XRAM_DW)) u_xram (
    .clk(clk), .we(xr_we), .waddr(xr_waddr), .wdata(xr_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      idx_q     <= '0;
      valid_q   <= 1'b0;
      is_addr_q <= 1'b0;
      paddr_q   <= '0;
    end else begin
      if (kind == FK_NAME) flag_q <= hit_nt;
      if (hit_nt)          idx_q  <= idx_now;
      valid_q   <= hit_nt | hit_at | hit_pt;
      is_addr_q <= hit_pt;
      paddr_q   <= hit_pt ? {BANK_W'(cfg.bank), fetch_addr[11:3], vs[2:0]} : '0;
    end
  end

  assign ovr_valid   = valid_q;
  assign ovr_is_addr = is_addr_q;
  assign ovr_data    = (valid_q && !is_addr_q) ? rd_data : 8'h00;
  assign ovr_paddr   = paddr_q;

  assign unused_bits = {^fetch_addr[2:0], ^idx_q[6:5], ^idx_q[1:0]};
endmodule

// File: rtl/split_fetch_sub_chk.sv
module split_fetch_sub_chk #(
  parameter int PADDR_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_valid,
  input logic [13:0]        fetch_addr,
  input logic               in_frame,
  input logic [7:0]         line_cnt,
  input logic [7:0]         scroll_q,
  input logic               ovr_valid,
  input logic               ovr_is_addr,
  input logic [PADDR_W-1:0] ovr_paddr
);
  AST_NO_FETCH_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fetch_valid) |-> !ovr_valid); // R5
  AST_OUT_OF_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_frame) |-> !ovr_valid); // R9
  AST_ADDR_ONLY_FROM_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && ovr_is_addr) |-> !$past(fetch_addr[13])); // R11
  AST_DATA_ONLY_FROM_TABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && !ovr_is_addr) |-> $past(fetch_addr[13])); // R11
  AST_PATTERN_ROW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && ovr_is_addr) |-> (ovr_paddr[11:3] == $past(fetch_addr[11:3]))); // R7
  AST_PATTERN_FINE_SCROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && ovr_is_addr) |-> (ovr_paddr[2:0] == $past(3'(scroll_q[2:0] + line_cnt[2:0])))); // R4
endmodule

bind split_fetch_sub split_fetch_sub_chk #(.PADDR_W(BANK_W + 12)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .in_frame(in_frame), .line_cnt(line_cnt), .scroll_q(scroll_q),
  .ovr_valid(ovr_valid), .ovr_is_addr(ovr_is_addr), .ovr_paddr(ovr_paddr)
);

// File: tb/split_fetch_sub_tb.sv
module split_fetch_sub_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic xr_we = 1'b0;
  logic [9:0] xr_waddr = '0;
  logic [7:0] xr_wdata = '0;
  logic fetch_valid = 1'b0;
  logic [13:0] fetch_addr = '0;
  logic line_start = 1'b0;
  logic in_frame = 1'b0;
  logic [7:0] line_cnt = '0;
  logic ovr_valid, ovr_is_addr;
  logic [7:0] ovr_data;
  logic [17:0] ovr_paddr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_fetch_sub u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xr_we(xr_we), .xr_waddr(xr_waddr), .xr_wdata(xr_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .line_start(line_start),
    .in_frame(in_frame), .line_cnt(line_cnt),
    .ovr_valid(ovr_valid), .ovr_is_addr(ovr_is_addr), .ovr_data(ovr_data), .ovr_paddr(ovr_paddr)
  );

  // stimulus for the next cycle
  int d_fv = 0, d_fa = 0, d_ls = 0, d_inf = 0, d_lc = 0;
  int d_cwe = 0, d_csel = 0, d_cwd = 0, d_xwe = 0, d_xwa = 0, d_xwd = 0;

  // reference model state
  int m_mem [1024];
  int m_count = 0, m_flag = 0, m_idx = 0;
  int m_en = 0, m_right = 0, m_delim = 0, m_scroll = 0, m_bank = 0, m_mode = 0;

  int vectors = 0, miscompares = 0;
  string cur_tag = "R1";

  task automatic cycle();
    int kind, col, vs, act, inband;
    int e_v, e_k, e_d, e_p;
    string tg;
    fetch_valid = d_fv[0]; fetch_addr = 14'(d_fa); line_start = d_ls[0];
    in_frame = d_inf[0]; line_cnt = 8'(d_lc);
    cfg_we = d_cwe[0]; cfg_sel = 3'(d_csel); cfg_wdata = 8'(d_cwd);
    xr_we = d_xwe[0]; xr_waddr = 10'(d_xwa); xr_wdata = 8'(d_xwd);
    // classify: 0 none, 1 nametable, 2 attribute, 3 pattern (R11)
    if (d_fv == 0) kind = 0;
    else if (d_fa >= 'h2000 && d_fa < 'h3000 && (d_fa % 1024) < 960) kind = 1;
    else if (d_fa >= 'h2000) kind = 2;
    else kind = 3;
    if (kind == 1) m_count++;
    if (d_ls != 0) m_count = 0;
    col = (m_count + 2) % 42;
    vs = (m_scroll + d_lc) % 240;
    act = (m_en != 0 && m_mode <= 1 && d_inf != 0) ? 1 : 0;
    e_v = 0; e_k = 0; e_d = 0; e_p = 0;
    tg = cur_tag;
    if (kind == 1) begin
      inband = (col <= 32 && ((m_right != 0) ? (col >= m_delim) : (col < m_delim))) ? 1 : 0;
      if (act != 0 && inband != 0) begin
        m_flag = 1; m_idx = ((vs / 8) * 32) | col;
        e_v = 1; e_d = m_mem[m_idx];
      end else m_flag = 0;
      tg = {tg, " R5"};
    end else if (kind == 2) begin
      if (act != 0 && m_flag != 0) begin
        e_v = 1;
        e_d = m_mem[960 + ((m_idx / 128) % 8) * 8 + (m_idx % 32) / 4];
      end
      tg = {tg, " R6"};
    end else if (kind == 3) begin
      if (act != 0 && m_flag != 0) begin
        e_v = 1; e_k = 1;
        e_p = (m_bank % 64) * 4096 + ((d_fa % 4096) / 8) * 8 + (vs % 8);
      end
      tg = {tg, " R7"};
    end
    if (d_xwe != 0) m_mem[d_xwa] = d_xwd;
    if (d_cwe != 0) begin
      case (d_csel)
        0: begin m_en = d_cwd % 2; m_right = (d_cwd / 2) % 2; end
        1: m_delim = d_cwd % 32;
        2: m_scroll = d_cwd;
        3: m_bank = d_cwd;
        4: m_mode = d_cwd % 4;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (ovr_valid !== e_v[0] || ovr_is_addr !== e_k[0] ||
        ovr_data !== 8'(e_d) || ovr_paddr !== 18'(e_p)) begin
      miscompares++;
      $display("FAIL %s: v/k/data/paddr actual %0d/%0d/%02h/%05h expected %0d/%0d/%02h/%05h",
               tg, ovr_valid, ovr_is_addr, ovr_data, ovr_paddr, e_v, e_k, e_d, e_p);
    end
    d_ls = 0; d_cwe = 0; d_xwe = 0;
  endtask

  task automatic wcfg(input int sel, input int val);
    d_fv = 0; d_cwe = 1; d_csel = sel; d_cwd = val;
    cycle();
  endtask

  // one scanline: nametable, attribute, two pattern fetches per tile
  task automatic run_line(input int lc, input int ntiles, input int start,
                          input int nt_base, input int at_base);
    d_lc = lc;
    for (int t = 0; t < ntiles; t++) begin
      d_fv = 1; d_ls = (t == 0) ? start : 0;
      d_fa = nt_base + (t * 5) % 960;                cycle();
      d_fa = at_base + t % 64;                       cycle();
      d_fa = ((t * 16 + lc) * 8 + 5) % 'h2000;       cycle();
      d_fa = ((t * 16 + lc) * 8 + 8 + 2) % 'h2000;   cycle();
    end
    d_fv = 0; cycle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle outputs
    cur_tag = "R1";
    repeat (3) cycle();
    // R12: fill expansion RAM
    cur_tag = "R12";
    for (int i = 0; i < 1024; i++) begin
      d_xwe = 1; d_xwa = i; d_xwd = (i * 37 + 11) % 256; d_fv = 0;
      cycle();
    end
    // R10: program registers
    cur_tag = "R10";
    wcfg(4, 1); wcfg(0, 1); wcfg(1, 10); wcfg(2, 5); wcfg(3, 'h47);
    d_inf = 1;
    // R5 R6 R7 R8: left band, delimiter 10
    cur_tag = "R5";
    run_line(0, 42, 1, 'h2000, 'h23C0);
    run_line(100, 42, 1, 'h2400, 'h27C0);
    // R4: scroll wrap-around
    cur_tag = "R4";
    wcfg(2, 250);
    run_line(239, 42, 1, 'h2000, 'h23C0);
    run_line(231, 42, 1, 'h2800, 'h2BC0);
    // R3: right side, delimiter edges
    cur_tag = "R3";
    wcfg(0, 3); wcfg(1, 20);
    run_line(17, 42, 1, 'h2000, 'h23C0);
    wcfg(1, 0);
    run_line(18, 42, 1, 'h2000, 'h23C0);
    wcfg(0, 1); wcfg(1, 31);
    run_line(19, 42, 1, 'h2000, 'h23C0);
    // R2: count beyond one wrap, lone line start then line without start
    cur_tag = "R2";
    run_line(20, 50, 1, 'h2000, 'h23C0);
    d_ls = 1; d_fv = 0; cycle();
    run_line(21, 42, 0, 'h2000, 'h23C0);
    // R9: gating by in-frame, mode and enable; count keeps running
    cur_tag = "R9";
    wcfg(0, 3); wcfg(1, 12);
    d_inf = 0; run_line(22, 42, 1, 'h2000, 'h23C0);
    d_inf = 1; wcfg(4, 2); run_line(23, 42, 1, 'h2000, 'h23C0);
    wcfg(4, 3); run_line(23, 10, 1, 'h2000, 'h23C0);
    wcfg(4, 0); wcfg(0, 2); run_line(24, 42, 1, 'h2000, 'h23C0);
    wcfg(0, 3);
    d_inf = 0; run_line(25, 20, 1, 'h2000, 'h23C0);
    d_inf = 1; run_line(25, 22, 0, 'h2000, 'h23C0);
    // R8: band flag cleared by an out-of-band nametable fetch
    cur_tag = "R8";
    wcfg(0, 1); wcfg(1, 4);
    run_line(26, 12, 1, 'h2000, 'h23C0);
    // R11: upper nametable corner and attribute fetches in the 0x3000 range
    cur_tag = "R11";
    wcfg(1, 30);
    run_line(27, 42, 1, 'h2C00, 'h3000);
    d_fv = 1; d_ls = 1; d_fa = 'h2FBF; cycle();
    d_fa = 'h2BFF; cycle();
    d_fa = 'h3FFF; cycle();
    d_fa = 'h1FFF; cycle();
    // R10: register write alongside a fetch
    cur_tag = "R10";
    d_fv = 1; d_ls = 1; d_fa = 'h2000; d_cwe = 1; d_csel = 2; d_cwd = 77; cycle();
    d_fa = 'h0123; cycle();
    d_fa = 'h2001; d_cwe = 1; d_csel = 3; d_cwd = 'hC5; cycle();
    d_fa = 'h0456; cycle();
    // R12: expansion RAM write to the index being read
    cur_tag = "R12";
    d_lc = 0; wcfg(2, 0);
    d_fv = 1; d_ls = 1; d_fa = 'h2000; d_xwe = 1; d_xwa = 2; d_xwd = 'hA5; cycle();
    d_ls = 1; d_fa = 'h2000; cycle();
    d_fv = 0; cycle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule